// File: doc/BRIEF.md
# ModR/M and SIB Addressing Decoder

This block sits behind the prefix and opcode stages of an x86 instruction decoder. It receives, in a single parallel word, the addressing bytes that follow a one-byte primary opcode, beginning with the ModR/M byte. It also receives the four REX flag bits and a flag that says whether the core runs in 64-bit mode. One clock later it presents a registered record for the address generator. The record gives the operand kind, the register numbers widened by REX, and the raw opcode-extension digit. It also gives the scale-index-base breakdown, the displacement width and its sign-extended value, a PC-relative flag, and the number of addressing bytes consumed.

The ModR/M byte is byte 0, in bits 7:0 of the input word. A SIB byte, when present, is byte 1. The displacement follows directly after the last of these bytes, least significant byte first. The consumed-byte count covers the ModR/M byte, the SIB byte and the displacement. It does not include the opcode or the prefix.

Top module: `modrm_sib_decoder`

## Requirements
- R1: The ModR/M byte splits into mode (bits 7:6), reg (bits 5:3) and rm (bits 2:0). `ext_digit` is the raw 3-bit reg field, and `reg_num` is {REX.R, reg}.
- R2: When mode = 11, the operand is a register (`is_reg`=1). `rm_base` is {REX.B, rm}, there is no SIB and no displacement, and `byte_count` is 1.
- R3: When mode = 01, one displacement byte follows and is sign-extended to 32 bits (`disp_size`=1). When mode = 10, four bytes follow, least significant first (`disp_size`=2). When there is no displacement, `disp_size` is 0 and `disp` is 0.
- R4: When rm = 100 and mode ≠ 11, byte 1 is a SIB byte (`has_sib`=1). It holds scale in bits 7:6, index in bits 5:3 and base in bits 2:0, and the displacement starts at byte 2.
- R5: The index register is {REX.X, index}. The value 0100 means no index (`index_none`=1). Without a SIB byte, `index_none`=1, `index_num`=0 and `sib_scale`=0.
- R6: A SIB base field of 101 with mode = 00 means no base (`base_none`=1, `rm_base`=0) plus a 32-bit displacement. REX.B does not change this. With mode 01 or 10 the base is {REX.B, 101}. Otherwise a memory operand's `rm_base` is {REX.B, base or rm}.
- R7: mode = 00 with raw rm = 101 means no base plus a 32-bit displacement, whatever the value of REX.B. `rip_rel` is 1 for this form in 64-bit mode and 0 outside it. A SIB no-base form never sets `rip_rel`.
- R8: REX bits (order {W,R,X,B}) take effect only when `long_mode`=1. Otherwise they are treated as zero. `op_wide` reports the effective W.
- R9: `byte_count` is 1, plus 1 if a SIB byte is present, plus the number of displacement bytes. For example, 14 81 gives 2, 54 81 xx gives 3, 94 81 + 4 bytes gives 6, and 15 + 4 bytes gives 5.
- R10: `out_valid` follows `in_valid` one clock later. The decoded fields of that cycle appear together with it. A synchronous reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Addressing bytes present this cycle |
| long_mode | input | 1 | Core is in 64-bit mode |
| rex | input | 4 | REX flags {W,R,X,B} |
| addr_bytes | input | 8*MAX_BYTES | Byte 0 = ModR/M, then SIB and displacement |
| out_valid | output | 1 | Decoded record valid |
| is_reg | output | 1 | Register-direct operand |
| op_wide | output | 1 | 64-bit operand size selected |
| reg_num | output | 4 | Register from the reg field |
| ext_digit | output | 3 | Raw reg field used as opcode extension |
| rm_base | output | 4 | Direct register or memory base register |
| has_sib | output | 1 | SIB byte consumed |
| sib_scale | output | 2 | Scale code (factor 1,2,4,8) |
| index_num | output | 4 | Index register |
| index_none | output | 1 | No index register |
| base_none | output | 1 | No base register |
| rip_rel | output | 1 | Address relative to the next instruction |
| disp_size | output | 2 | 0 none, 1 byte, 2 four bytes |
| disp | output | DISP_W | Sign-extended displacement |
| byte_count | output | clog2(MAX_BYTES+1) | Addressing bytes consumed |

## Verification
The bench runs known encodings in both modes. They cover SIB with and without displacement, the bare-displacement form, the register-direct form and the zero-disp8 base-13 escape. These separate the three length rules, and they separate PC-relative from absolute addressing. The same bytes are replayed with REX bits set, once in 64-bit mode and once outside it. This shows both that REX widens the register numbers and that REX.B cannot turn the no-base forms into a base register. A stream of arbitrary bytes, flags and valid gaps, compared against a behavioural model on every clock, covers the remaining combinations of mode, rm and SIB fields.

// File: rtl/mrm_pkg.sv
package mrm_pkg;
  typedef enum logic [1:0] {
    DSZ_NONE = 2'd0,
    DSZ_8    = 2'd1,
    DSZ_32   = 2'd2
  } dsz_t;

  localparam logic [1:0] MODE_IND  = 2'b00;
  localparam logic [1:0] MODE_D8   = 2'b01;
  localparam logic [1:0] MODE_D32  = 2'b10;
  localparam logic [1:0] MODE_REG  = 2'b11;
  localparam logic [2:0] RM_ESCAPE = 3'b100;
  localparam logic [2:0] RM_NOBASE = 3'b101;
endpackage

// File: rtl/mrm_amode.sv
module mrm_amode
  import mrm_pkg::*;
(
  input  logic [1:0] mode_f,
  input  logic [2:0] rm_f,
  output logic       is_reg,
  output logic       need_sib,
  output logic       plain_abs
);
  always_comb begin
    is_reg    = (mode_f == MODE_REG);
    need_sib  = !is_reg && (rm_f == RM_ESCAPE);
    // decided on the raw 3-bit field: REX.B never reaches this compare
    plain_abs = (mode_f == MODE_IND) && (rm_f == RM_NOBASE);
  end
endmodule

// File: rtl/mrm_sib.sv
module mrm_sib
  import mrm_pkg::*;
(
  input  logic [7:0] sib_byte,
  input  logic [1:0] mode_f,
  input  logic       rex_x,
  output logic [1:0] scale,
  output logic [3:0] idx_num,
  output logic       idx_none,
  output logic [2:0] base_fld,
  output logic       base_abs
);
  always_comb begin
    scale    = sib_byte[7:6];
    idx_num  = {rex_x, sib_byte[5:3]};
    idx_none = (idx_num == 4'b0100);
    base_fld = sib_byte[2:0];
    base_abs = (mode_f == MODE_IND) && (base_fld == RM_NOBASE);
  end
endmodule

// File: rtl/mrm_disp.sv
module mrm_disp
  import mrm_pkg::*;
#(
  parameter int IN_W   = 48,
  parameter int DISP_W = 32
) (
  input  logic [IN_W-1:0]   bytes,
  input  logic              after_sib,
  input  dsz_t              dsel,
  output logic [DISP_W-1:0] disp
);
  logic [DISP_W-1:0] win;

  always_comb begin
    win = after_sib ? bytes[16 +: DISP_W] : bytes[8 +: DISP_W];
    unique case (dsel)
      DSZ_8:   disp = {{(DISP_W-8){win[7]}}, win[7:0]};
      DSZ_32:  disp = win;
      default: disp = '0;
    endcase
  end
endmodule

// File: rtl/modrm_sib_decoder.sv
module modrm_sib_decoder
  import mrm_pkg::*;
#(
  parameter int MAX_BYTES = 6,
  parameter int DISP_W    = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_valid,
  input  logic                             long_mode,
  input  logic [3:0]                       rex,
  input  logic [8*MAX_BYTES-1:0]           addr_bytes,
  output logic                             out_valid,
  output logic                             is_reg,
  output logic                             op_wide,
  output logic [3:0]                       reg_num,
  output logic [2:0]                       ext_digit,
  output logic [3:0]                       rm_base,
  output logic                             has_sib,
  output logic [1:0]                       sib_scale,
  output logic [3:0]                       index_num,
  output logic                             index_none,
  output logic                             base_none,
  output logic                             rip_rel,
  output logic [1:0]                       disp_size,
  output logic [DISP_W-1:0]                disp,
  output logic [$clog2(MAX_BYTES+1)-1:0]   byte_count
);
  localparam int IN_W  = 8*MAX_BYTES;
  localparam int CNT_W = $clog2(MAX_BYTES+1);
  localparam int D32_B = DISP_W/8;

  typedef struct packed {
    logic              is_reg;
    logic              wide;
    logic [3:0]        reg_n;
    logic [2:0]        digit;
    logic [3:0]        rmb;
    logic              sib;
    logic [1:0]        scale;
    logic [3:0]        idx;
    logic              idx_none;
    logic              base_none;
    logic              rip;
    dsz_t              dsz;
    logic [DISP_W-1:0] disp;
    logic [CNT_W-1:0]  cnt;
  } dec_t;

  logic [3:0] rex_eff;
  logic [1:0] mode_f;
  logic [2:0] reg_f, rm_f;
  logic       c_is_reg, c_need_sib, c_plain_abs;
  logic [1:0] s_scale;
  logic [3:0] s_idx;
  logic       s_idx_none, s_base_abs;
  logic [2:0] s_base;
  dsz_t       c_dsz;
  logic [DISP_W-1:0] c_disp;
  dec_t       nxt, cur;
  logic       vld_q;

  assign rex_eff = long_mode ? rex : 4'h0;
  assign mode_f  = addr_bytes[7:6];
  assign reg_f   = addr_bytes[5:3];
  assign rm_f    = addr_bytes[2:0];

  mrm_amode u_amode (
    .mode_f(mode_f), .rm_f(rm_f),
    .is_reg(c_is_reg), .need_sib(c_need_sib), .plain_abs(c_plain_abs)
  );

  mrm_sib u_sib (
    .sib_byte(addr_bytes[15:8]), .mode_f(mode_f), .rex_x(rex_eff[1]),
    .scale(s_scale), .idx_num(s_idx), .idx_none(s_idx_none),
    .base_fld(s_base), .base_abs(s_base_abs)
  );

  always_comb begin
    unique case (mode_f)
      MODE_D8:  c_dsz = DSZ_8;
      MODE_D32: c_dsz = DSZ_32;
      MODE_IND: c_dsz = (c_need_sib ? s_base_abs : c_plain_abs) ? DSZ_32 : DSZ_NONE;
      default:  c_dsz = DSZ_NONE;
    endcase
  end

  mrm_disp #(.IN_W(IN_W), .DISP_W(DISP_W)) u_disp (
    .bytes(addr_bytes), .after_sib(c_need_sib), .dsel(c_dsz), .disp(c_disp)
  );

  always_comb begin
    nxt           = '0;
    nxt.is_reg    = c_is_reg;
    nxt.wide      = rex_eff[3];
    nxt.reg_n     = {rex_eff[2], reg_f};
    nxt.digit     = reg_f;
    nxt.sib       = c_need_sib;
    nxt.scale     = c_need_sib ? s_scale : 2'b00;
    nxt.idx       = c_need_sib ? s_idx : 4'h0;
    nxt.idx_none  = c_need_sib ? s_idx_none : 1'b1;
    nxt.base_none = !c_is_reg && (c_need_sib ? s_base_abs : c_plain_abs);
    nxt.rip       = long_mode && !c_is_reg && !c_need_sib && c_plain_abs;
    nxt.rmb       = nxt.base_none ? 4'h0 :
                    {rex_eff[0], (c_need_sib ? s_base : rm_f)};
    nxt.dsz       = c_dsz;
    nxt.disp      = c_disp;
    nxt.cnt       = CNT_W'(1) + CNT_W'(c_need_sib) +
                    ((c_dsz == DSZ_8)  ? CNT_W'(1) :
                     (c_dsz == DSZ_32) ? CNT_W'(D32_B) : CNT_W'(0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      cur   <= '0;
    end else begin
      vld_q <= in_valid;
      cur   <= nxt;
    end
  end

  assign out_valid  = vld_q;
  assign is_reg     = cur.is_reg;
  assign op_wide    = cur.wide;
  assign reg_num    = cur.reg_n;
  assign ext_digit  = cur.digit;
  assign rm_base    = cur.rmb;
  assign has_sib    = cur.sib;
  assign sib_scale  = cur.scale;
  assign index_num  = cur.idx;
  assign index_none = cur.idx_none;
  assign base_none  = cur.base_none;
  assign rip_rel    = cur.rip;
  assign disp_size  = cur.dsz;
  assign disp       = cur.disp;
  assign byte_count = cur.cnt;

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10
  AST_IDLE_LAT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R10
  AST_REG_SHORT: assert property (@(posedge clk) disable iff (rst)
    out_valid && is_reg |-> byte_count == CNT_W'(1) && !has_sib && disp_size == 2'd0); // R2
  AST_SIB_LEN: assert property (@(posedge clk) disable iff (rst)
    out_valid && has_sib |-> byte_count >= CNT_W'(2) && !is_reg); // R4
  AST_RIP_MODE: assert property (@(posedge clk) disable iff (rst)
    out_valid && rip_rel |-> $past(long_mode) && base_none && !has_sib); // R7
  AST_NOBASE_D32: assert property (@(posedge clk) disable iff (rst)
    out_valid && base_none |-> disp_size == 2'd2); // R6
  AST_WIDE_MODE: assert property (@(posedge clk) disable iff (rst)
    out_valid && op_wide |-> $past(long_mode)); // R8
endmodule

// File: tb/modrm_sib_decoder_tb.sv
module modrm_sib_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        long_mode = 1'b0;
  logic [3:0]  rex = 4'h0;
  logic [47:0] addr_bytes = '0;
  logic        out_valid, is_reg, op_wide, has_sib, index_none, base_none, rip_rel;
  logic [3:0]  reg_num, rm_base, index_num;
  logic [2:0]  ext_digit, byte_count;
  logic [1:0]  sib_scale, disp_size;
  logic [31:0] disp;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // expected record for the vector driven on the previous negedge
  bit      e_v;
  int      e_reg, e_digit, e_rmb, e_scale, e_idx, e_dsz, e_cnt;
  bit      e_isreg, e_wide, e_sib, e_inone, e_bnone, e_rip;
  longint  e_disp;

  always #5 clk = ~clk;

  modrm_sib_decoder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .long_mode(long_mode), .rex(rex),
    .addr_bytes(addr_bytes), .out_valid(out_valid), .is_reg(is_reg), .op_wide(op_wide),
    .reg_num(reg_num), .ext_digit(ext_digit), .rm_base(rm_base), .has_sib(has_sib),
    .sib_scale(sib_scale), .index_num(index_num), .index_none(index_none),
    .base_none(base_none), .rip_rel(rip_rel), .disp_size(disp_size), .disp(disp),
    .byte_count(byte_count)
  );

  task automatic chk(string req, string name, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, name, act, exp);
    end
  endtask

  task automatic compare_prev();
    chk("R10", "out_valid", out_valid, e_v);
    if (e_v) begin
      chk("R1", "reg_num", reg_num, e_reg);
      chk("R1", "ext_digit", ext_digit, e_digit);
      chk("R2", "is_reg", is_reg, e_isreg);
      chk("R6", "rm_base", rm_base, e_rmb);
      chk("R4", "has_sib", has_sib, e_sib);
      chk("R4", "sib_scale", sib_scale, e_scale);
      chk("R5", "index_num", index_num, e_idx);
      chk("R5", "index_none", index_none, e_inone);
      chk("R6", "base_none", base_none, e_bnone);
      chk("R7", "rip_rel", rip_rel, e_rip);
      chk("R8", "op_wide", op_wide, e_wide);
      chk("R3", "disp_size", disp_size, e_dsz);
      chk("R3", "disp", disp, e_disp);
      chk("R9", "byte_count", byte_count, e_cnt);
    end
  endtask

  task automatic put(bit v, bit lm, bit [3:0] rx, bit [47:0] b);
    int md, rg, rm, p, bf, nd;
    bit w, r, x, bb;
    longint raw;
    @(negedge clk);
    compare_prev();
    in_valid = v; long_mode = lm; rex = rx; addr_bytes = b;
    w = lm & rx[3]; r = lm & rx[2]; x = lm & rx[1]; bb = lm & rx[0];
    md = b[7:6]; rg = b[5:3]; rm = b[2:0];
    e_v = v; e_reg = r*8 + rg; e_digit = rg; e_wide = w;
    e_isreg = (md == 3); e_sib = 0; e_scale = 0; e_idx = 0; e_inone = 1;
    e_bnone = 0; e_rip = 0; e_dsz = 0; e_disp = 0; p = 1;
    if (md == 3) begin
      e_rmb = bb*8 + rm;
    end else begin
      bf = rm;
      if (rm == 4) begin
        e_sib = 1; p = 2;
        e_scale = b[15:14]; e_idx = x*8 + b[13:11];
        e_inone = (e_idx == 4); bf = b[10:8];
        e_bnone = (md == 0 && bf == 5);
      end else begin
        e_bnone = (md == 0 && rm == 5);
        e_rip = e_bnone && lm;
      end
      e_rmb = e_bnone ? 0 : bb*8 + bf;
      if (md == 1) e_dsz = 1;
      else if (md == 2 || e_bnone) e_dsz = 2;
    end
    nd = (e_dsz == 1) ? 1 : (e_dsz == 2) ? 4 : 0;
    raw = 0;
    for (int i = nd - 1; i >= 0; i--) raw = raw * 256 + ((b >> (8*(p+i))) & 8'hFF);
    if (e_dsz == 1 && raw >= 128) raw = raw + 64'hFFFF_FF00;
    e_disp = raw;
    e_cnt = p + nd;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    e_v = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "out_valid in reset", out_valid, 0);
    rst = 0;
    // R4 R9: SIB forms with none / disp8 / disp32
    put(1, 0, 4'h0, 48'h0000_0000_8114);
    put(1, 0, 4'h0, 48'h0000_0020_8154);
    put(1, 0, 4'h0, 48'h0040_3020_8194);
    // R7: bare disp32, legacy then 64-bit
    put(1, 0, 4'h0, 48'h0040_3020_1015);
    put(1, 1, 4'h0, 48'h0040_3020_1015);
    // R1 R7 R8: REX W+R, reg 13, relative
    put(1, 1, 4'hC, 48'h00ff_ead9_ed2d);
    // R7: REX.B set, still relative, no base
    put(1, 1, 4'h1, 48'h0011_2233_4405);
    // R6: base 13 via disp8 of zero
    put(1, 1, 4'h1, 48'h0000_0000_0045);
    // R2: register direct, digit 2
    put(1, 0, 4'h0, 48'h0000_0000_00D0);
    put(1, 1, 4'h1, 48'h0000_0000_00D4);
    // R8: REX ignored outside 64-bit mode
    put(1, 0, 4'hF, 48'h0000_0000_00D4);
    // R3: negative disp8
    put(1, 0, 4'h0, 48'h0000_0000_F050);
    // R5: index 100 with and without REX.X
    put(1, 1, 4'h0, 48'h0000_0000_2404);
    put(1, 1, 4'h2, 48'h0000_0000_6404);
    // R6: SIB no-base with REX.B, and base 101 with disp8
    put(1, 1, 4'h1, 48'h7856_3412_2504);
    put(1, 1, 4'h1, 48'h0000_0008_2544);
    // R10: gap
    put(0, 0, 4'h0, 48'h0);
    for (int n = 0; n < 2000; n++)
      put(($urandom % 4) != 0, $urandom % 2, 4'($urandom),
          {16'($urandom), $urandom});
    put(0, 0, 4'h0, 48'h0);
    put(0, 0, 4'h0, 48'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule